// File: doc/BRIEF.md
# Pin Sense Latch

This block watches a group of general-purpose input pins and records, per pin, that a programmed level condition has occurred. Each pin carries a two-bit sense setting that selects off, active-high or active-low. The pin is first passed through a two-flop synchronizer. When the synchronized level matches the setting, the pin's bit in a sticky latch register is set. The bit keeps its value when the pin later stops matching.

Software reads and writes two registers over a small strobe interface: the sense configuration and the latch. A latch bit is cleared by writing a one to its position. A zero leaves it alone. A single registered detect output is the OR of all latch bits, and drives a wake-up or interrupt request. While any latch bit is still set, detect stays high. A new event on a pin whose bit is still set therefore produces no new rising edge, so software must clear the latched bits to re-arm the output.

Top module: `pin_sense_latch`

## Requirements
- R1: A pin whose sense field is 2'b10 sets latch bit n (bit position equal to the pin number) when its synchronized level is 1. A pin whose field is 2'b11 sets bit n when its level is 0.
- R2: A set latch bit remains 1 after the pin stops meeting its sense condition, until software clears it.
- R3: A write with reg_sel_i=1 and a 1 in bit n of reg_wdata_i clears latch bit n, provided the pin does not meet its condition in that cycle.
- R4: Zero bits in a latch write leave the corresponding latch bits unchanged.
- R5: detect_o is, one cycle later, the OR of all latch bits. While any bit remains set, a further pin event does not make detect_o fall and rise again.
- R6: When a pin meets its condition in the same cycle as a clearing write to its bit, the bit stays 1.
- R7: A pin whose sense field is 2'b00 (off) or 2'b01 (reserved) never sets its latch bit.
- R8: A write with reg_sel_i=0 loads the sense fields (pin n in bits 2n+1:2n) and reads back unchanged. It does not alter the latch.
- R9: After reset, all sense fields are off, the latch is zero, detect_o is 0 and the read data is 0.
- R10: A pin change is latched at the third rising clock edge after it is applied, and detect_o rises at the fourth.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| pins_i | input | NUM_PINS | Asynchronous pin levels |
| reg_sel_i | input | 1 | Register select: 0 sense configuration, 1 latch |
| reg_we_i | input | 1 | Write strobe for the selected register |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Registered read data of the selected register |
| detect_o | output | 1 | Registered OR of all latch bits |

## Verification
On every cycle, the assertions check the following: set bits survive unless cleared, a clear without a coinciding set empties the bit, a pending set always lands, detect follows the OR of the latch, off and reserved pins never latch, and the state is clean after reset. Only the bench scenarios can show the three-edge latency, the bit positions for high and low sensing, and the configuration readback. They also show the masking effect, where a second event behind an uncleared bit yields no new detect edge, and that a clear has to be repeated once a held-active pin is released.

// File: rtl/psl_pkg.sv
package psl_pkg;

  typedef enum logic [1:0] {
    SENSE_OFF  = 2'b00,
    SENSE_RSVD = 2'b01,
    SENSE_HIGH = 2'b10,
    SENSE_LOW  = 2'b11
  } sense_mode_e;

  localparam logic SEL_CFG   = 1'b0;
  localparam logic SEL_LATCH = 1'b1;

  localparam int unsigned SENSE_BITS = 2;

endpackage

// File: rtl/psl_sync.sv
module psl_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= async_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/psl_sense_eval.sv
module psl_sense_eval
  import psl_pkg::*;
#(
  parameter int unsigned NUM_PINS = 8,
  localparam int unsigned CFG_W   = NUM_PINS * SENSE_BITS
) (
  input  logic [CFG_W-1:0]    cfg_i,
  input  logic [NUM_PINS-1:0] level_i,
  output logic [NUM_PINS-1:0] hit_o
);

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    sense_mode_e mode;
    assign mode = sense_mode_e'(cfg_i[g*SENSE_BITS +: SENSE_BITS]);

    always_comb begin
      unique case (mode)
        SENSE_HIGH: hit_o[g] = level_i[g];
        SENSE_LOW:  hit_o[g] = ~level_i[g];
        default:    hit_o[g] = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/psl_latch_bank.sv
module psl_latch_bank #(
  parameter int unsigned NUM_PINS = 8
) (
  input  logic                clk_i,
  input  logic                rst_i,
  input  logic [NUM_PINS-1:0] set_i,
  input  logic [NUM_PINS-1:0] clr_i,
  output logic [NUM_PINS-1:0] latch_o
);

  logic [NUM_PINS-1:0] latch_q;

  // a set in the same cycle as a clear overrides it
  always_ff @(posedge clk_i) begin
    if (rst_i) latch_q <= '0;
    else       latch_q <= (latch_q & ~clr_i) | set_i;
  end

  assign latch_o = latch_q;

  AST_STICKY_BITS: assert property (@(posedge clk_i) disable iff (rst_i)
    1'b1 |=> (($past(latch_q) & ~$past(clr_i) & ~latch_q) == '0)); // R2 R4

  AST_CLEAR_TAKES: assert property (@(posedge clk_i) disable iff (rst_i)
    1'b1 |=> (($past(clr_i & ~set_i) & latch_q) == '0)); // R3

  AST_SET_LANDS: assert property (@(posedge clk_i) disable iff (rst_i)
    1'b1 |=> (($past(set_i) & ~latch_q) == '0)); // R6

endmodule

// File: rtl/pin_sense_latch.sv
module pin_sense_latch
  import psl_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 8,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_i,
  input  logic [NUM_PINS-1:0] pins_i,
  input  logic                reg_sel_i,
  input  logic                reg_we_i,
  input  logic [DATA_W-1:0]   reg_wdata_i,
  output logic [DATA_W-1:0]   reg_rdata_o,
  output logic                detect_o
);

  localparam int unsigned CFG_W = NUM_PINS * SENSE_BITS;

  if (CFG_W > DATA_W) begin : g_bad_width
    $error("sense configuration does not fit the data width");
  end

  logic [CFG_W-1:0]    cfg_q;
  logic [NUM_PINS-1:0] level_sync;
  logic [NUM_PINS-1:0] hit;
  logic [NUM_PINS-1:0] clr;
  logic [NUM_PINS-1:0] latch;
  logic [NUM_PINS-1:0] off_mask;
  logic [DATA_W-1:0]   rd_next;
  logic                detect_q;
  logic [DATA_W-1:0]   rdata_q;

  psl_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .async_i (pins_i),
    .sync_o  (level_sync)
  );

  psl_sense_eval #(.NUM_PINS(NUM_PINS)) u_eval (
    .cfg_i   (cfg_q),
    .level_i (level_sync),
    .hit_o   (hit)
  );

  assign clr = (reg_we_i && reg_sel_i == SEL_LATCH) ? reg_wdata_i[NUM_PINS-1:0] : '0;

  psl_latch_bank #(.NUM_PINS(NUM_PINS)) u_latch (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .set_i   (hit),
    .clr_i   (clr),
    .latch_o (latch)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i)                                  cfg_q <= '0;
    else if (reg_we_i && reg_sel_i == SEL_CFG) cfg_q <= reg_wdata_i[CFG_W-1:0];
  end

  always_comb begin
    rd_next = '0;
    if (reg_sel_i == SEL_LATCH) rd_next[NUM_PINS-1:0] = latch;
    else                        rd_next[CFG_W-1:0]    = cfg_q;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      rdata_q  <= '0;
      detect_q <= 1'b0;
    end else begin
      rdata_q  <= rd_next;
      detect_q <= |latch;
    end
  end

  assign reg_rdata_o = rdata_q;
  assign detect_o    = detect_q;

  if (CFG_W < DATA_W) begin : g_spare
    logic unused_wdata;
    assign unused_wdata = ^reg_wdata_i[DATA_W-1:CFG_W];
  end

  // pins whose field has the upper bit clear are off or reserved
  for (genvar g = 0; g < NUM_PINS; g++) begin : g_off
    assign off_mask[g] = ~cfg_q[g*SENSE_BITS + 1];
  end

  AST_DETECT_FOLLOWS: assert property (@(posedge clk_i) disable iff (rst_i)
    1'b1 |=> (detect_o == $past(|latch))); // R5

  AST_OFF_NEVER_SETS: assert property (@(posedge clk_i) disable iff (rst_i)
    1'b1 |=> ((latch & ~$past(latch) & $past(off_mask)) == '0)); // R7

  AST_RESET_CLEAN: assert property (@(posedge clk_i)
    $past(rst_i) |-> (latch == '0 && cfg_q == '0 && !detect_o && reg_rdata_o == '0)); // R9

endmodule

// File: tb/pin_sense_latch_bench.sv
module pin_sense_latch_bench;

  localparam int unsigned NP = 8;
  localparam int unsigned DW = 32;

  logic          clk = 1'b0;
  logic          rst;
  logic [NP-1:0] pins;
  logic          sel;
  logic          we;
  logic [DW-1:0] wdata;
  logic [DW-1:0] rdata;
  logic          detect;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  pin_sense_latch #(.NUM_PINS(NP), .DATA_W(DW)) u_pin_sense_latch (
    .clk_i       (clk),
    .rst_i       (rst),
    .pins_i      (pins),
    .reg_sel_i   (sel),
    .reg_we_i    (we),
    .reg_wdata_i (wdata),
    .reg_rdata_o (rdata),
    .detect_o    (detect)
  );

  task automatic check_eq(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rd(logic s, output logic [DW-1:0] v);
    @(negedge clk);
    sel = s;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    v = rdata;
  endtask

  task automatic wr(logic s, logic [DW-1:0] d);
    @(negedge clk);
    sel = s; we = 1'b1; wdata = d;
    @(negedge clk);
    we = 1'b0; wdata = '0;
  endtask

  // sense fields: pin0 high, pin1 low, pin2 high, pin3 off, pin4 reserved
  localparam logic [DW-1:0] CFG_A = 32'h0000_012E;

  task automatic t_reset();
    logic [DW-1:0] v;
    check_eq("R9 detect after reset", {31'd0, detect}, 0);
    check_eq("R9 rdata after reset", rdata, 0);
    rd(1'b0, v); check_eq("R9 cfg after reset", v, 0);
    rd(1'b1, v); check_eq("R9 latch after reset", v, 0);
  endtask

  task automatic t_config();
    logic [DW-1:0] v;
    wr(1'b0, CFG_A);
    rd(1'b0, v); check_eq("R8 cfg readback", v, CFG_A);
    idle(4);
    rd(1'b1, v); check_eq("R8 cfg write leaves latch", v, 0);
  endtask

  task automatic t_latency_sticky();
    logic [DW-1:0] v;
    @(negedge clk); pins[0] = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_eq("R10 detect low after third edge", {31'd0, detect}, 0);
    @(posedge clk); @(negedge clk);
    check_eq("R10 detect high after fourth edge", {31'd0, detect}, 1);
    rd(1'b1, v); check_eq("R1 high sense bit position", v, 32'h01);
    pins[0] = 1'b0;
    idle(5);
    rd(1'b1, v); check_eq("R2 bit holds after pin returns", v, 32'h01);
    check_eq("R2 detect holds", {31'd0, detect}, 1);
  endtask

  task automatic t_write_clear();
    logic [DW-1:0] v;
    wr(1'b1, 32'h00);
    rd(1'b1, v); check_eq("R4 zero write keeps latch", v, 32'h01);
    wr(1'b1, 32'hFE);
    rd(1'b1, v); check_eq("R4 zero in bit0 keeps it", v, 32'h01);
    wr(1'b1, 32'h01);
    rd(1'b1, v); check_eq("R3 one clears bit", v, 32'h00);
    check_eq("R5 detect falls when latch empty", {31'd0, detect}, 0);
  endtask

  task automatic t_low_and_masking();
    logic [DW-1:0] v;
    bit dropped = 1'b0;
    @(negedge clk); pins[1] = 1'b0;
    idle(5);
    rd(1'b1, v); check_eq("R1 low sense bit position", v, 32'h02);
    check_eq("R5 detect from low sense", {31'd0, detect}, 1);
    pins[2] = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (!detect) dropped = 1'b1;
    end
    check_eq("R5 no new detect edge behind set bit", {31'd0, dropped}, 0);
    rd(1'b1, v); check_eq("R5 second event latched", v, 32'h06);
    pins[1] = 1'b1;
    idle(4);
    wr(1'b1, 32'h02);
    rd(1'b1, v); check_eq("R3 clear only selected bit", v, 32'h04);
    check_eq("R5 detect held by remaining bit", {31'd0, detect}, 1);
  endtask

  task automatic t_set_wins();
    logic [DW-1:0] v;
    wr(1'b1, 32'h04);
    rd(1'b1, v); check_eq("R6 set beats clear while pin active", v, 32'h04);
    @(negedge clk); pins[2] = 1'b0;
    idle(4);
    wr(1'b1, 32'h04);
    rd(1'b1, v); check_eq("R6 clear after release", v, 32'h00);
    idle(1);
    check_eq("R5 detect low after full clear", {31'd0, detect}, 0);
  endtask

  task automatic t_off_pins();
    logic [DW-1:0] v;
    @(negedge clk); pins[3] = 1'b1; pins[4] = 1'b1; pins[7] = 1'b1;
    idle(6);
    pins[3] = 1'b0; pins[4] = 1'b0; pins[7] = 1'b0;
    idle(6);
    rd(1'b1, v); check_eq("R7 off and reserved pins never latch", v, 0);
    check_eq("R7 detect stays low", {31'd0, detect}, 0);
  endtask

  task automatic t_rearm();
    logic [DW-1:0] v;
    @(negedge clk); pins[0] = 1'b1;
    idle(5);
    check_eq("R5 detect rises again after re-arm", {31'd0, detect}, 1);
    pins[0] = 1'b0;
    idle(3);
    wr(1'b0, 32'h0);
    rd(1'b0, v); check_eq("R8 cfg cleared", v, 0);
    rd(1'b1, v); check_eq("R8 cfg write keeps latched bit", v, 32'h01);
  endtask

  initial begin
    rst = 1'b1; pins = 8'b0000_0010; sel = 1'b0; we = 1'b0; wdata = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    idle(1);
    t_reset();
    t_config();
    t_latency_sticky();
    t_write_clear();
    t_low_and_masking();
    t_set_wins();
    t_off_pins();
    t_rearm();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule